// File: doc/BRIEF.md
# Rotate, Shift and Bit-Test Unit

This block carries out the prefixed single-operand byte operations of a small 8-bit processor. These are the four rotates (through carry and circular, each in both directions), the left shift, the arithmetic and logical right shifts, the nibble exchange, and the test, clear and set of one selected bit. The caller gives an operand, the current flags, a 4-bit operation code and a bit index. When the operation finishes, the block returns the result, the new flags and a write-back enable. A mode input selects the fast accumulator form of the rotates, and in that form the zero flag is always cleared.

The operand can be a register value or a byte in memory. For a register operand the result is ready one cycle after `start`. For a memory operand, a built-in sequencer reads the byte at the supplied pointer through a byte-wide synchronous memory port, applies the operation, and writes the byte back to the same address. The write is skipped when the operation is a bit test. The block does no instruction decode.

Top module: `shiftbit_unit`

## Requirements
- R1: Op 0 rotates left through carry: the result is {operand[6:0], C} and bit 7 goes to C. Op 1 rotates right through carry: the result is {C, operand[7:1]} and bit 0 goes to C. The flags are packed as bit 3 = Z, bit 2 = N, bit 1 = H, bit 0 = C.
- R2: Op 2 rotates left circularly and op 3 rotates right circularly. In both, the bit that leaves one end enters the other end and is also copied into C.
- R3: Op 4 shifts left and inserts 0. Op 5 shifts right and keeps bit 7. Op 6 shifts right and inserts 0. In each case the bit shifted out goes to C.
- R4: Op 7 exchanges the two nibbles and clears C.
- R5: For ops 0 to 7, Z is set exactly when the result is zero, N and H are cleared, and the write-back enable is high.
- R6: With `acc_mode` high, ops 0 to 3 clear Z even when the result is zero. `acc_mode` has no effect on any other op.
- R7: Op 8 tests bit `bit_idx` (0 to 7). It sets Z when that bit is 0, clears N, sets H and keeps C. The result equals the operand and the write-back enable is low.
- R8: Op 9 clears bit `bit_idx` and op 10 sets it. No other bit changes, all flags are kept and the write-back enable is high.
- R9: Op codes 11 to 15 return the operand and the flags unchanged, with the write-back enable low.
- R10: With `use_mem` low, `done` pulses in the cycle after `start` is sampled, and there is no memory read or write.
- R11: With `use_mem` high, `mem_rd` is high with `mem_addr` equal to `hl_addr` in the first cycle after `start`. `done` is high two cycles later. In that same cycle, if the write-back enable is high, `mem_wr` is high and `mem_wdata` holds the result for the same address.
- R12: A memory-operand bit test (op 8) never asserts `mem_wr`, so the byte in memory is left unchanged.
- R13: `start` is ignored while an operation is in progress.
- R14: After reset, `done`, `mem_rd` and `mem_wr` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation (sampled only when idle) |
| op | input | 4 | Operation code, 0 to 10 |
| bit_idx | input | 3 | Bit index for test, clear and set |
| acc_mode | input | 1 | Accumulator rotate form (Z forced to 0) |
| use_mem | input | 1 | Operand lives in memory at `hl_addr` |
| reg_in | input | 8 | Register operand |
| flags_in | input | 4 | Incoming flags {Z,N,H,C} |
| hl_addr | input | 16 | Memory pointer for the memory operand |
| mem_rdata | input | 8 | Read data, valid the cycle after `mem_rd` |
| mem_addr | output | 16 | Memory address |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Memory write data |
| res_out | output | 8 | Result, valid with `done` and held afterwards |
| flags_out | output | 4 | New flags {Z,N,H,C} |
| wb_en | output | 1 | Write-back enable for the result |
| done | output | 1 | Operation complete |

## Verification
A wrong sequencer state shows up at the memory strobes within one cycle. Examples are a read strobe that lasts two cycles, a write during a bit test, or a `done` that arrives at the wrong distance from `start`. The reference model predicts every strobe on every clock. A wrong datapath state, such as a stale latched operation or flag, shows up only at `done` as a wrong result or a wrong flag nibble, so each op is run with both carry values and with operands that give zero results.

// File: rtl/shiftbit_pkg.sv
package shiftbit_pkg;
   typedef enum logic [3:0] {
      SB_RLT = 4'd0, SB_RRT = 4'd1, SB_RLC = 4'd2, SB_RRC = 4'd3,
      SB_SHL = 4'd4, SB_SRA = 4'd5, SB_SRL = 4'd6, SB_SWP = 4'd7,
      SB_TST = 4'd8, SB_CLR = 4'd9, SB_SET = 4'd10
   } sb_op_e;

   typedef struct packed {
      logic z;
      logic n;
      logic h;
      logic c;
   } sb_flags_t;

   typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_CALC, ST_FIN} sb_state_e;
endpackage

// File: rtl/shiftbit_mask.sv
module shiftbit_mask #(
   parameter int DATA_W = 8,
   localparam int IDX_W = $clog2(DATA_W)
) (
   input  logic [IDX_W-1:0]  idx,
   output logic [DATA_W-1:0] mask
);
   for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      assign mask[i] = (idx == IDX_W'(i));
   end
endmodule

// File: rtl/shiftbit_core.sv
module shiftbit_core
   import shiftbit_pkg::*;
#(
   parameter int DATA_W = 8,
   localparam int IDX_W = $clog2(DATA_W),
   localparam int MSB   = DATA_W - 1,
   localparam int HALF  = DATA_W / 2
) (
   input  logic [3:0]        op,
   input  logic [IDX_W-1:0]  idx,
   input  logic              acc_mode,
   input  logic [DATA_W-1:0] opnd,
   input  sb_flags_t         fin,
   output logic [DATA_W-1:0] res,
   output sb_flags_t         fout,
   output logic              wb
);
   logic [DATA_W-1:0] mask;
   logic              cout;
   logic              shift_grp;
   logic              rot_grp;

   shiftbit_mask #(.DATA_W(DATA_W)) u_mask (.idx(idx), .mask(mask));

   always_comb begin
      res       = opnd;
      fout      = fin;
      wb        = 1'b1;
      cout      = 1'b0;
      shift_grp = 1'b1;
      rot_grp   = 1'b0;
      case (op)
         SB_RLT: begin res = {opnd[MSB-1:0], fin.c}; cout = opnd[MSB]; rot_grp = 1'b1; end
         SB_RRT: begin res = {fin.c, opnd[MSB:1]};   cout = opnd[0];   rot_grp = 1'b1; end
         SB_RLC: begin res = {opnd[MSB-1:0], opnd[MSB]}; cout = opnd[MSB]; rot_grp = 1'b1; end
         SB_RRC: begin res = {opnd[0], opnd[MSB:1]};     cout = opnd[0];   rot_grp = 1'b1; end
         SB_SHL: begin res = {opnd[MSB-1:0], 1'b0};      cout = opnd[MSB]; end
         SB_SRA: begin res = {opnd[MSB], opnd[MSB:1]};   cout = opnd[0];   end
         SB_SRL: begin res = {1'b0, opnd[MSB:1]};        cout = opnd[0];   end
         SB_SWP: begin res = {opnd[HALF-1:0], opnd[MSB:HALF]}; cout = 1'b0; end
         SB_TST: begin
            shift_grp = 1'b0;
            wb        = 1'b0;
            fout.z    = ~|(opnd & mask);
            fout.n    = 1'b0;
            fout.h    = 1'b1;
         end
         SB_CLR: begin shift_grp = 1'b0; res = opnd & ~mask; end
         SB_SET: begin shift_grp = 1'b0; res = opnd | mask;  end
         default: begin shift_grp = 1'b0; wb = 1'b0; end
      endcase
      if (shift_grp) begin
         fout.z = (res == '0) & ~(acc_mode & rot_grp);
         fout.n = 1'b0;
         fout.h = 1'b0;
         fout.c = cout;
      end
   end
endmodule

// File: rtl/shiftbit_seq.sv
module shiftbit_seq
   import shiftbit_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 16,
   localparam int IDX_W = $clog2(DATA_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [3:0]        op,
   input  logic [IDX_W-1:0]  bit_idx,
   input  logic              acc_mode,
   input  logic              use_mem,
   input  logic [DATA_W-1:0] reg_in,
   input  sb_flags_t         flags_in,
   input  logic [ADDR_W-1:0] hl_addr,
   input  logic [DATA_W-1:0] mem_rdata,
   // core side
   output logic [3:0]        c_op,
   output logic [IDX_W-1:0]  c_idx,
   output logic              c_acc,
   output logic [DATA_W-1:0] c_opnd,
   output sb_flags_t         c_fin,
   input  logic [DATA_W-1:0] c_res,
   input  sb_flags_t         c_fout,
   input  logic              c_wb,
   // results
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic [DATA_W-1:0] res_q,
   output sb_flags_t         flags_q,
   output logic              wb_q,
   output logic              done
);
   sb_state_e         state;
   logic [3:0]        op_q;
   logic [IDX_W-1:0]  idx_q;
   logic              acc_q;
   logic              mem_q;
   sb_flags_t         fin_q;
   logic [ADDR_W-1:0] addr_q;

   wire in_calc = (state == ST_CALC);
   wire take    = (state == ST_IDLE) && start;

   assign c_op   = in_calc ? op_q     : op;
   assign c_idx  = in_calc ? idx_q    : bit_idx;
   assign c_acc  = in_calc ? acc_q    : acc_mode;
   assign c_opnd = in_calc ? mem_rdata : reg_in;
   assign c_fin  = in_calc ? fin_q    : flags_in;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         op_q    <= '0;
         idx_q   <= '0;
         acc_q   <= 1'b0;
         mem_q   <= 1'b0;
         fin_q   <= '0;
         addr_q  <= '0;
         res_q   <= '0;
         flags_q <= '0;
         wb_q    <= 1'b0;
      end else begin
         case (state)
            ST_IDLE: if (take) begin
               op_q   <= op;
               idx_q  <= bit_idx;
               acc_q  <= acc_mode;
               fin_q  <= flags_in;
               addr_q <= hl_addr;
               mem_q  <= use_mem;
               if (use_mem) begin
                  state <= ST_READ;
               end else begin
                  res_q   <= c_res;
                  flags_q <= c_fout;
                  wb_q    <= c_wb;
                  state   <= ST_FIN;
               end
            end
            ST_READ: state <= ST_CALC;
            ST_CALC: begin
               res_q   <= c_res;
               flags_q <= c_fout;
               wb_q    <= c_wb;
               state   <= ST_FIN;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign mem_addr = addr_q;
   assign mem_rd   = (state == ST_READ);
   assign done     = (state == ST_FIN);
   assign mem_wr   = done & mem_q & wb_q;
endmodule

// File: rtl/shiftbit_unit.sv
module shiftbit_unit
   import shiftbit_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 16,
   localparam int IDX_W = $clog2(DATA_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [3:0]        op,
   input  logic [IDX_W-1:0]  bit_idx,
   input  logic              acc_mode,
   input  logic              use_mem,
   input  logic [DATA_W-1:0] reg_in,
   input  logic [3:0]        flags_in,
   input  logic [ADDR_W-1:0] hl_addr,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic [DATA_W-1:0] mem_wdata,
   output logic [DATA_W-1:0] res_out,
   output logic [3:0]        flags_out,
   output logic              wb_en,
   output logic              done
);
   if (DATA_W < 2 || (DATA_W % 2) != 0) begin : g_chk_w
      $error("shiftbit_unit: DATA_W must be even and at least 2");
   end
   if (ADDR_W < 1) begin : g_chk_a
      $error("shiftbit_unit: ADDR_W must be positive");
   end

   logic [3:0]        c_op;
   logic [IDX_W-1:0]  c_idx;
   logic              c_acc;
   logic [DATA_W-1:0] c_opnd;
   sb_flags_t         c_fin;
   logic [DATA_W-1:0] c_res;
   sb_flags_t         c_fout;
   logic              c_wb;
   sb_flags_t         flags_q;

   shiftbit_core #(.DATA_W(DATA_W)) u_core (
      .op(c_op), .idx(c_idx), .acc_mode(c_acc), .opnd(c_opnd), .fin(c_fin),
      .res(c_res), .fout(c_fout), .wb(c_wb)
   );

   shiftbit_seq #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .op(op), .bit_idx(bit_idx),
      .acc_mode(acc_mode), .use_mem(use_mem), .reg_in(reg_in),
      .flags_in(sb_flags_t'(flags_in)), .hl_addr(hl_addr), .mem_rdata(mem_rdata),
      .c_op(c_op), .c_idx(c_idx), .c_acc(c_acc), .c_opnd(c_opnd), .c_fin(c_fin),
      .c_res(c_res), .c_fout(c_fout), .c_wb(c_wb),
      .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
      .res_q(res_out), .flags_q(flags_q), .wb_q(wb_en), .done(done)
   );

   assign flags_out = flags_q;
   assign mem_wdata = res_out;
endmodule

// File: rtl/shiftbit_chk.sv
module shiftbit_chk #(
   parameter int ADDR_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              use_mem,
   input logic [ADDR_W-1:0] hl_addr,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              mem_rd,
   input logic              mem_wr,
   input logic              wb_en,
   input logic              done
);
   AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(mem_rd && mem_wr)); // R11
   AST_RD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) mem_rd |=> (!mem_rd && !done)); // R11
   AST_WR_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n) mem_wr |-> (done && wb_en)); // R12
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R10
   AST_RD_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n) mem_rd |-> !done); // R13
   AST_RD_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n) mem_rd |=> $stable(mem_addr)); // R11
endmodule

bind shiftbit_unit shiftbit_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .use_mem(use_mem), .hl_addr(hl_addr),
   .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr), .wb_en(wb_en), .done(done)
);

// File: tb/sim_shiftbit_unit.sv
`timescale 1ns/1ps
module sim_shiftbit_unit;
   localparam real CLK_P = 5.0;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [3:0]  op = '0;
   logic [2:0]  bit_idx = '0;
   logic        acc_mode = 1'b0;
   logic        use_mem = 1'b0;
   logic [7:0]  reg_in = '0;
   logic [3:0]  flags_in = '0;
   logic [15:0] hl_addr = '0;
   logic [7:0]  mem_rdata;
   logic [15:0] mem_addr;
   logic        mem_rd, mem_wr, wb_en, done;
   logic [7:0]  mem_wdata, res_out;
   logic [3:0]  flags_out;

   int n_chk = 0;
   int n_err = 0;
   logic [7:0] bmem [16];

   always #(CLK_P/2) clk = ~clk;

   shiftbit_unit u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .op(op), .bit_idx(bit_idx),
      .acc_mode(acc_mode), .use_mem(use_mem), .reg_in(reg_in), .flags_in(flags_in),
      .hl_addr(hl_addr), .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_rd(mem_rd),
      .mem_wr(mem_wr), .mem_wdata(mem_wdata), .res_out(res_out), .flags_out(flags_out),
      .wb_en(wb_en), .done(done)
   );

   // synchronous byte memory of the bench
   always @(posedge clk) begin
      if (mem_rd) mem_rdata <= bmem[mem_addr[3:0]];
      if (mem_wr) bmem[mem_addr[3:0]] <= mem_wdata;
   end

   task automatic check(input string rq, input int act, input int exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
      end
   endtask

   // behavioural reference: returns {wb, flags[3:0], result[7:0]}
   function automatic int model(int o, int idx, int acc, int a, int f);
      int r, z, n, h, c, wb, grp;
      r = a; z = (f >> 3) & 1; n = (f >> 2) & 1; h = (f >> 1) & 1; c = f & 1;
      wb = 1; grp = 1;
      case (o)
         0: begin r = ((a << 1) | c) & 255; c = a >> 7; end
         1: begin r = (a >> 1) | (c << 7); c = a & 1; end
         2: begin r = ((a << 1) | (a >> 7)) & 255; c = a >> 7; end
         3: begin r = (a >> 1) | ((a & 1) << 7); c = a & 1; end
         4: begin r = (a << 1) & 255; c = a >> 7; end
         5: begin r = (a >> 1) | (a & 128); c = a & 1; end
         6: begin r = a >> 1; c = a & 1; end
         7: begin r = ((a << 4) | (a >> 4)) & 255; c = 0; end
         8: begin grp = 0; wb = 0; z = ((a >> idx) & 1) ? 0 : 1; n = 0; h = 1; end
         9: begin grp = 0; r = a & ~(1 << idx) & 255; end
         10: begin grp = 0; r = a | (1 << idx); end
         default: begin grp = 0; wb = 0; end
      endcase
      if (grp) begin
         z = (r == 0 && !(acc && o < 4)) ? 1 : 0;
         n = 0; h = 0;
      end
      return (wb << 12) | (z << 11) | (n << 10) | (h << 9) | (c << 8) | r;
   endfunction

   task automatic run_reg(input string rq, input int o, input int idx, input int acc,
                          input int a, input int f);
      int e;
      e = model(o, idx, acc, a, f);
      @(negedge clk);
      start = 1; op = 4'(o); bit_idx = 3'(idx); acc_mode = acc[0]; use_mem = 0;
      reg_in = 8'(a); flags_in = 4'(f);
      @(negedge clk);
      start = 0;
      check({rq, " done"}, done, 1);
      check({rq, " no mem"}, {mem_rd, mem_wr}, 0);
      check({rq, " result"}, res_out, e & 255);
      check({rq, " flags"}, flags_out, (e >> 8) & 15);
      check({rq, " wb"}, wb_en, (e >> 12) & 1);
      @(negedge clk);
      check({rq, " done pulse"}, done, 0);
   endtask

   task automatic run_mem(input string rq, input int o, input int idx, input int f,
                          input int adr, input bit poke_start);
      int e, a;
      a = bmem[adr];
      e = model(o, idx, 0, a, f);
      @(negedge clk);
      start = 1; op = 4'(o); bit_idx = 3'(idx); acc_mode = 0; use_mem = 1;
      flags_in = 4'(f); hl_addr = 16'(16'h4A00 + adr); reg_in = 8'h5A;
      @(negedge clk);
      // R13: a second start during the read is ignored
      start = poke_start; op = 4'd10; bit_idx = 3'd7; use_mem = 0; hl_addr = 16'h0003;
      check({rq, " read strobe"}, mem_rd, 1);
      check({rq, " read addr"}, mem_addr, 16'h4A00 + adr);
      check({rq, " not done"}, done, 0);
      @(negedge clk);
      start = 0;
      check({rq, " calc idle"}, {mem_rd, done, mem_wr}, 0);
      @(negedge clk);
      check({rq, " done"}, done, 1);
      check({rq, " result"}, res_out, e & 255);
      check({rq, " flags"}, flags_out, (e >> 8) & 15);
      check({rq, " write"}, mem_wr, (e >> 12) & 1);
      check({rq, " wdata"}, mem_wdata, e & 255);
      @(negedge clk);
      check({rq, " mem byte"}, bmem[adr], ((e >> 12) & 1) ? (e & 255) : a);
      check({rq, " no restart"}, {done, mem_rd}, 0);
   endtask

   initial begin
      #(CLK_P * 100000);
      n_err++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      for (int i = 0; i < 16; i++) bmem[i] = 8'(i * 37 + 5);
      bmem[2] = 8'h00; bmem[3] = 8'h81; bmem[4] = 8'hF7;
      repeat (3) @(negedge clk);
      check("R14 reset outputs", {done, mem_rd, mem_wr}, 0);
      rst_n = 1;
      @(negedge clk);
      check("R14 idle after reset", {done, mem_rd, mem_wr}, 0);

      run_reg("R1 rlt c0", 0, 0, 0, 8'h85, 4'h0);
      run_reg("R1 rlt c1", 0, 0, 0, 8'h40, 4'h1);
      run_reg("R1 rrt c1", 1, 0, 0, 8'h01, 4'h1);
      run_reg("R1 rrt zero", 1, 0, 0, 8'h01, 4'hE);
      run_reg("R2 rlc", 2, 0, 0, 8'h81, 4'h0);
      run_reg("R2 rrc", 3, 0, 0, 8'h01, 4'h0);
      run_reg("R3 shl", 4, 0, 0, 8'h80, 4'h0);
      run_reg("R3 sra", 5, 0, 0, 8'h81, 4'h0);
      run_reg("R3 srl", 6, 0, 0, 8'h81, 4'h0);
      run_reg("R4 swap", 7, 0, 0, 8'h3C, 4'h1);
      run_reg("R5 swap zero", 7, 0, 0, 8'h00, 4'h7);
      run_reg("R6 acc rlt zero", 0, 0, 1, 8'h80, 4'h0);
      run_reg("R6 acc rrc", 3, 0, 1, 8'h00, 4'h0);
      run_reg("R6 acc ignored srl", 6, 0, 1, 8'h01, 4'h0);
      run_reg("R6 acc ignored tst", 8, 2, 1, 8'h00, 4'h1);
      for (int b = 0; b < 8; b++) begin
         run_reg("R7 tst one", 8, b, 0, 1 << b, 4'h1);
         run_reg("R7 tst zero", 8, b, 0, ~(1 << b) & 255, 4'h4);
         run_reg("R8 clr", 9, b, 0, 8'hFF, 4'h5);
         run_reg("R8 set", 10, b, 0, 8'h00, 4'hA);
      end
      run_reg("R9 spare op", 11, 0, 0, 8'h00, 4'h6);
      run_reg("R9 spare op", 15, 3, 1, 8'hC3, 4'h9);
      run_reg("R10 back to back", 4, 0, 0, 8'h7F, 4'h1);

      run_mem("R11 mem rlt", 0, 0, 4'h1, 4, 0);
      run_mem("R11 mem set", 10, 3, 4'h0, 2, 0);
      run_mem("R12 mem tst", 8, 7, 4'h1, 3, 0);
      run_mem("R12 mem tst zero", 8, 1, 4'h0, 4, 0);
      run_mem("R13 start while busy", 6, 0, 4'h0, 5, 1);
      run_mem("R11 mem swap", 7, 0, 4'h1, 9, 0);

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule